// File: doc/BRIEF.md
# Four-Channel Match Timer

This is a memory-mapped timer with four independent 32-bit counters. Each counter has its own compare value. Three per-channel action bits decide what happens when a running counter equals its compare value: raise a status flag, return the counter to zero, or halt the channel. With these bits software can set up a free-running time base, a periodic tick or a one-shot event. Each channel also has an enable, a synchronous clear, a count direction and a clock-source select. All channels share one prescale value, and each channel keeps its own prescale counter.

The register bus is a simple one. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational from `bus_addr`. Every register base has four word addresses. Address bits [3:2] pick the write action: 0 is a plain write, 1 sets bits, 2 clears bits and 3 toggles bits. An address whose bits [1:0] are not zero is treated as unmapped.

Top module: `quad_match_timer`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero and `irq` is low.
- R2: For the control (0x10), direction (0x20), prescale (0x70), action (0x90), compare (0xA0/0xB0/0xC0/0xD0) and source-select (0x180) registers, writing at base+0x0 loads the data, base+0x4 ORs it in, base+0x8 clears the written 1-bits, and base+0xC inverts them.
- R3: Writes to the counter registers (0x30, 0x40, 0x50, 0x60) and to the prescale counter (0x80) have no effect. Reads of unmapped addresses return zero. Status bit 4 always reads zero.
- R4: A channel n counts when its enable (control bit n) is set and its source field is 0. It takes one step every (prescale+1) clocks and wraps modulo 2^32.
- R5: While control bit n+4 is set, channel n's counter and prescale counter read zero, starting from the second edge after the bit is written.
- R6: A direction field (bits 4n+3:4n) of value 1 makes channel n count down; any other value counts up. A wrap in either direction sets no flag.
- R7: Each channel's prescale counter runs 0..prescale and then restarts with a counter step. Address 0x80 reads channel 0's prescale counter.
- R8: A match occurs when an enabled, non-cleared counter equals its compare value. A match sets status bit n at the next edge. If action bit 3n+1 is set, the step taken at a match goes to zero instead of ±1.
- R9: A match with action bit 3n+2 set clears control bit n at the next edge, overriding a software write in the same cycle. The counter holds, or goes to zero if bit 3n+1 is also set.
- R10: `irq` is high exactly when some status bit n is set while action bit 3n is set.
- R11: Writing 1s to status (0x00) at alias 0 or 2 clears those bits. Aliases 1 and 3 have no effect. A match in the same cycle as a clear wins.
- R12: A channel whose source field (bits 2n+1:2n of 0x180) is not 0 does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| irq | output | 1 | Interrupt request |

## Verification
A register write becomes visible on read data in the cycle after its edge. A match detected in one cycle shows up in the status flag and `irq`, and in the cleared enable for a stop action, after the next edge. A clear bit needs two edges before the counters read zero: one to store the bit and one to clear the counters. The bench model advances at the same rising edge as the design and applies these same latencies. Reads and the per-cycle `irq` comparison are sampled on the falling edge, after every register on the path has settled.

// File: rtl/qmt_pkg.sv
package qmt_pkg;
    localparam int NCH    = 4;
    localparam int CW     = 32;
    localparam int CTRL_W = 2 * NCH;
    localparam int DIR_W  = 4 * NCH;
    localparam int ACT_W  = 3 * NCH;
    localparam int SRC_W  = 2 * NCH;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2,
        OP_INV  = 2'd3
    } wop_e;

    localparam logic [7:0] BASE_STAT = 8'h00;
    localparam logic [7:0] BASE_CTRL = 8'h01;
    localparam logic [7:0] BASE_DIR  = 8'h02;
    localparam logic [7:0] BASE_CNT0 = 8'h03;
    localparam logic [7:0] BASE_CNT3 = 8'h06;
    localparam logic [7:0] BASE_PRE  = 8'h07;
    localparam logic [7:0] BASE_PCNT = 8'h08;
    localparam logic [7:0] BASE_ACT  = 8'h09;
    localparam logic [7:0] BASE_CMP0 = 8'h0A;
    localparam logic [7:0] BASE_CMP3 = 8'h0D;
    localparam logic [7:0] BASE_SRC  = 8'h18;

    typedef struct packed {
        logic [CTRL_W-1:0]       ctrl;
        logic [DIR_W-1:0]        dir;
        logic [CW-1:0]           pre;
        logic [ACT_W-1:0]        act;
        logic [SRC_W-1:0]        src;
        logic [NCH-1:0]          flag;
        logic [NCH-1:0][CW-1:0]  cmp;
        logic [NCH-1:0][CW-1:0]  cnt;
        logic [NCH-1:0][CW-1:0]  pcnt;
    } regs_t;
endpackage

// File: rtl/qmt_alias.sv
module qmt_alias
    import qmt_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] wval,
    input  wop_e         op,
    output logic [W-1:0] nxt
);
    always_comb begin
        unique case (op)
            OP_LOAD: nxt = wval;
            OP_SET:  nxt = cur | wval;
            OP_CLR:  nxt = cur & ~wval;
            default: nxt = cur ^ wval;
        endcase
    end
endmodule

// File: rtl/qmt_channel.sv
module qmt_channel #(
    parameter int CW = 32
) (
    input  logic          en,
    input  logic          clr,
    input  logic          mode_ok,
    input  logic          down,
    input  logic          zero_on_hit,
    input  logic          halt_on_hit,
    input  logic [CW-1:0] cnt_q,
    input  logic [CW-1:0] pcnt_q,
    input  logic [CW-1:0] pre,
    input  logic [CW-1:0] cmp,
    output logic [CW-1:0] cnt_d,
    output logic [CW-1:0] pcnt_d,
    output logic          hit
);
    logic [CW-1:0] stepped;

    always_comb begin
        hit     = en && !clr && (cnt_q == cmp);
        stepped = down ? (cnt_q - CW'(1)) : (cnt_q + CW'(1));
        cnt_d   = cnt_q;
        pcnt_d  = pcnt_q;
        if (clr) begin
            cnt_d  = '0;
            pcnt_d = '0;
        end else if (en && mode_ok) begin
            if (hit && halt_on_hit) begin
                if (zero_on_hit) begin
                    cnt_d  = '0;
                    pcnt_d = '0;
                end
            end else if (pcnt_q >= pre) begin
                pcnt_d = '0;
                cnt_d  = (hit && zero_on_hit) ? '0 : stepped;
            end else begin
                pcnt_d = pcnt_q + CW'(1);
            end
        end
    end
endmodule

// File: rtl/quad_match_timer.sv
module quad_match_timer
    import qmt_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          irq
);
    localparam int BW = AW - 4;

    regs_t r_q, r_d;

    logic [NCH-1:0][CW-1:0] cnt_nx;
    logic [NCH-1:0][CW-1:0] pcnt_nx;
    logic [NCH-1:0]         hit;
    logic [NCH-1:0]         irq_en;
    logic [7:0]             base;
    logic                   aligned;
    logic [1:0]             cnt_idx;
    logic [1:0]             cmp_idx;
    logic [31:0]            rd_val;
    logic [31:0]            wr_val;
    wop_e                   op;

    assign base    = 8'(bus_addr[AW-1:4]);
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign op      = wop_e'(bus_addr[3:2]);
    assign cnt_idx = bus_addr[5:4] + 2'd1;
    assign cmp_idx = bus_addr[5:4] - 2'd2;

    // read mux, also the old value fed to the alias logic
    always_comb begin
        rd_val = '0;
        if (aligned) begin
            unique case (base)
                BASE_STAT: rd_val = 32'(r_q.flag);
                BASE_CTRL: rd_val = 32'(r_q.ctrl);
                BASE_DIR:  rd_val = 32'(r_q.dir);
                BASE_PRE:  rd_val = r_q.pre;
                BASE_PCNT: rd_val = r_q.pcnt[0];
                BASE_ACT:  rd_val = 32'(r_q.act);
                BASE_SRC:  rd_val = 32'(r_q.src);
                default: begin
                    if (base >= BASE_CNT0 && base <= BASE_CNT3)
                        rd_val = r_q.cnt[cnt_idx];
                    else if (base >= BASE_CMP0 && base <= BASE_CMP3)
                        rd_val = r_q.cmp[cmp_idx];
                end
            endcase
        end
    end
    assign bus_rdata = rd_val;

    qmt_alias #(.W(32)) u_alias (
        .cur  (rd_val),
        .wval (bus_wdata),
        .op   (op),
        .nxt  (wr_val)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        qmt_channel #(.CW(CW)) u_ch (
            .en          (r_q.ctrl[i]),
            .clr         (r_q.ctrl[NCH+i]),
            .mode_ok     (r_q.src[2*i +: 2] == 2'b00),
            .down        (r_q.dir[4*i +: 4] == 4'd1),
            .zero_on_hit (r_q.act[3*i+1]),
            .halt_on_hit (r_q.act[3*i+2]),
            .cnt_q       (r_q.cnt[i]),
            .pcnt_q      (r_q.pcnt[i]),
            .pre         (r_q.pre),
            .cmp         (r_q.cmp[i]),
            .cnt_d       (cnt_nx[i]),
            .pcnt_d      (pcnt_nx[i]),
            .hit         (hit[i])
        );
        assign irq_en[i] = r_q.act[3*i];
    end

    always_comb begin
        r_d = r_q;
        // software access first
        if (bus_sel && bus_wr && aligned) begin
            unique case (base)
                BASE_STAT: begin
                    if (op == OP_LOAD || op == OP_CLR)
                        r_d.flag = r_q.flag & ~bus_wdata[NCH-1:0];
                end
                BASE_CTRL: r_d.ctrl = wr_val[CTRL_W-1:0];
                BASE_DIR:  r_d.dir  = wr_val[DIR_W-1:0];
                BASE_PRE:  r_d.pre  = wr_val;
                BASE_ACT:  r_d.act  = wr_val[ACT_W-1:0];
                BASE_SRC:  r_d.src  = wr_val[SRC_W-1:0];
                default: begin
                    if (base >= BASE_CMP0 && base <= BASE_CMP3)
                        r_d.cmp[cmp_idx] = wr_val;
                end
            endcase
        end
        // hardware updates take priority
        for (int i = 0; i < NCH; i++) begin
            r_d.cnt[i]  = cnt_nx[i];
            r_d.pcnt[i] = pcnt_nx[i];
            if (hit[i]) begin
                r_d.flag[i] = 1'b1;
                if (r_q.act[3*i+2])
                    r_d.ctrl[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign irq = |(r_q.flag & irq_en);
endmodule

// File: rtl/qmt_checker.sv
module qmt_checker
    import qmt_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           irq,
    input regs_t          st,
    input logic [NCH-1:0] hit
);
    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R5: a clear bit held for two samples keeps both counters at zero
        a_r5_clear_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (st.ctrl[NCH+i] && $past(st.ctrl[NCH+i])) |-> (st.cnt[i] == '0 && st.pcnt[i] == '0));

        // R6: a flag can only rise after a match
        a_r6_flag_only_from_match: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(st.flag[i]) |-> $past(hit[i]));

        // R8: a match leaves its flag set
        a_r8_match_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |=> st.flag[i]);

        // R9: halt action drops the enable
        a_r9_halt_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[i] && st.act[3*i+2]) |=> !st.ctrl[i]);

        // R9: halt plus zero action leaves the counter at zero
        a_r9_oneshot_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[i] && st.act[3*i+2] && st.act[3*i+1]) |=> (st.cnt[i] == '0));
    end

    // R10: the request needs at least one pending flag
    a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|st.flag));
endmodule

bind quad_match_timer qmt_checker u_qmt_checker (
    .clk   (clk),
    .rst_n (rst_n),
    .irq   (irq),
    .st    (r_q),
    .hit   (hit)
);

// File: tb/quad_match_timer_test.sv
module quad_match_timer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  mon_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_match_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // ---------------- behavioural reference ----------------
    logic [31:0] m_cnt [4];
    logic [31:0] m_pcnt[4];
    logic [31:0] m_cmp [4];
    logic [31:0] m_pre;
    logic [7:0]  m_ctrl;
    logic [15:0] m_dir;
    logic [11:0] m_act;
    logic [7:0]  m_src;
    logic [3:0]  m_flag;

    function automatic logic [31:0] m_op(logic [31:0] old, logic [31:0] w, int kind);
        case (kind)
            0: return w;
            1: return old | w;
            2: return old & ~w;
            default: return old ^ w;
        endcase
    endfunction

    function automatic logic [31:0] m_read(logic [11:0] a);
        int reg_base = int'(a) & 12'hFF0;
        if (a[1:0] != 2'b00) return 32'h0;
        case (reg_base)
            12'h000: return {28'h0, m_flag};
            12'h010: return {24'h0, m_ctrl};
            12'h020: return {16'h0, m_dir};
            12'h030: return m_cnt[0];
            12'h040: return m_cnt[1];
            12'h050: return m_cnt[2];
            12'h060: return m_cnt[3];
            12'h070: return m_pre;
            12'h080: return m_pcnt[0];
            12'h090: return {20'h0, m_act};
            12'h0A0: return m_cmp[0];
            12'h0B0: return m_cmp[1];
            12'h0C0: return m_cmp[2];
            12'h0D0: return m_cmp[3];
            12'h180: return {24'h0, m_src};
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_cnt[i] = 0; m_pcnt[i] = 0; m_cmp[i] = 0;
            end
            m_pre = 0; m_ctrl = 0; m_dir = 0; m_act = 0; m_src = 0; m_flag = 0;
        end else begin
            logic [31:0] c[4], p[4], mm[4];
            logic [31:0] pre_n, old;
            logic [7:0]  ctrl_n, src_n;
            logic [15:0] dir_n;
            logic [11:0] act_n;
            logic [3:0]  flag_n;
            int kind, rb;
            for (int i = 0; i < 4; i++) begin c[i] = m_cnt[i]; p[i] = m_pcnt[i]; mm[i] = m_cmp[i]; end
            pre_n = m_pre; ctrl_n = m_ctrl; dir_n = m_dir; act_n = m_act; src_n = m_src; flag_n = m_flag;
            if (bus_sel && bus_wr && bus_addr[1:0] == 2'b00) begin
                kind = int'(bus_addr[3:2]);
                rb   = int'(bus_addr) & 12'hFF0;
                old  = m_read(bus_addr);
                case (rb)
                    12'h000: if (kind == 0 || kind == 2) flag_n = m_flag & ~bus_wdata[3:0];
                    12'h010: ctrl_n = m_op(old, bus_wdata, kind) & 32'hFF;
                    12'h020: dir_n  = 16'(m_op(old, bus_wdata, kind));
                    12'h070: pre_n  = m_op(old, bus_wdata, kind);
                    12'h090: act_n  = 12'(m_op(old, bus_wdata, kind));
                    12'h0A0: mm[0]  = m_op(old, bus_wdata, kind);
                    12'h0B0: mm[1]  = m_op(old, bus_wdata, kind);
                    12'h0C0: mm[2]  = m_op(old, bus_wdata, kind);
                    12'h0D0: mm[3]  = m_op(old, bus_wdata, kind);
                    12'h180: src_n  = 8'(m_op(old, bus_wdata, kind));
                    default: ;
                endcase
            end
            for (int i = 0; i < 4; i++) begin
                bit on, cl, match, halt, zero, dn, srcok;
                on    = m_ctrl[i];
                cl    = m_ctrl[4+i];
                match = on && !cl && (m_cnt[i] == m_cmp[i]);
                halt  = m_act[3*i+2];
                zero  = m_act[3*i+1];
                dn    = (m_dir[4*i +: 4] == 4'd1);
                srcok = (m_src[2*i +: 2] == 2'd0);
                if (cl) begin
                    c[i] = 0; p[i] = 0;
                end else if (on && srcok) begin
                    if (match && halt) begin
                        if (zero) begin c[i] = 0; p[i] = 0; end
                    end else if (m_pcnt[i] >= m_pre) begin
                        p[i] = 0;
                        if (match && zero) c[i] = 0;
                        else if (dn)       c[i] = m_cnt[i] - 1;
                        else               c[i] = m_cnt[i] + 1;
                    end else begin
                        p[i] = m_pcnt[i] + 1;
                    end
                end
                if (match) begin
                    flag_n[i] = 1'b1;
                    if (halt) ctrl_n[i] = 1'b0;
                end
            end
            for (int i = 0; i < 4; i++) begin m_cnt[i] = c[i]; m_pcnt[i] = p[i]; m_cmp[i] = mm[i]; end
            m_pre = pre_n; m_ctrl = ctrl_n; m_dir = dir_n; m_act = act_n; m_src = src_n; m_flag = flag_n;
        end
    end

    function automatic logic m_irq();
        return |(m_flag & {m_act[9], m_act[6], m_act[3], m_act[0]});
    endfunction

    // ---------------- checking helpers ----------------
    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // R10: per-cycle request comparison
    always @(negedge clk) begin
        if (mon_on) check("R10 irq", {31'h0, irq}, {31'h0, m_irq()});
    end

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic rd_model(string tag, logic [11:0] a);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, m_read(a));
    endtask

    task automatic rd_lit(string tag, logic [11:0] a, logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
        check({tag, " model"}, v, m_read(a));
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] a0, a1;
        idle(3);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R1: reset values
        rd_lit("R1 status", 12'h000, 0);
        rd_lit("R1 ctrl", 12'h010, 0);
        rd_lit("R1 cnt0", 12'h030, 0);
        rd_lit("R1 pcnt", 12'h080, 0);
        rd_lit("R1 act", 12'h090, 0);
        rd_lit("R1 src", 12'h180, 0);

        // R2: write aliases
        wr(12'h0B0, 32'h0000_F0F0);
        wr(12'h0B4, 32'h0000_0F00);
        rd_lit("R2 set", 12'h0B0, 32'h0000_FFF0);
        wr(12'h0B8, 32'h0000_00F0);
        rd_lit("R2 clear", 12'h0B0, 32'h0000_FF00);
        wr(12'h0BC, 32'h0000_FF0F);
        rd_lit("R2 toggle", 12'h0B0, 32'h0000_000F);
        wr(12'h18C, 32'h3);
        rd_lit("R2 src toggle", 12'h180, 32'h3);
        wr(12'h188, 32'h3);
        rd_lit("R2 src clear", 12'h180, 32'h0);

        // R3: read-only and unmapped
        wr(12'h030, 32'h1234);
        rd_lit("R3 cnt0 ro", 12'h030, 0);
        wr(12'h080, 32'h55);
        rd_lit("R3 pcnt ro", 12'h080, 0);
        rd_lit("R3 unmapped", 12'h0E0, 0);
        rd_lit("R3 misaligned", 12'h012, 0);

        // R4: free-running up count on channel 1
        wr(12'h0B0, 32'hFFFF_FFFF);
        wr(12'h014, 32'h2);
        idle(10);
        rd_model("R4 cnt1", 12'h040);
        wr(12'h018, 32'h2);
        rd_model("R4 cnt1 held", 12'h040);

        // R5: clear bit
        wr(12'h014, 32'h20);
        idle(3);
        rd_lit("R5 cnt1 cleared", 12'h040, 0);
        wr(12'h018, 32'h20);

        // R6: down count wraps without a flag
        wr(12'h024, 32'h100);
        wr(12'h0C0, 32'h7);
        wr(12'h014, 32'h4);
        idle(20);
        rd_model("R6 cnt2 down", 12'h050);
        rd_lit("R6 no wrap flag", 12'h000, 0);
        wr(12'h018, 32'h4);

        // R7: prescaler
        wr(12'h070, 32'h3);
        wr(12'h0A0, 32'hFFFF_FFFF);
        wr(12'h014, 32'h1);
        for (int k = 0; k < 6; k++) rd_model("R7 pcnt", 12'h080);
        rd_model("R7 cnt0 slow", 12'h030);
        wr(12'h018, 32'h1);
        wr(12'h070, 32'h0);
        wr(12'h014, 32'h10);
        idle(2);
        wr(12'h018, 32'h10);

        // R8/R10: periodic match with request
        wr(12'h094, 32'h3);
        wr(12'h0A0, 32'h4);
        wr(12'h014, 32'h1);
        idle(12);
        rd_model("R8 status", 12'h000);
        rd_model("R8 cnt0 periodic", 12'h030);
        wr(12'h018, 32'h1);

        // R11: status clearing rules
        wr(12'h004, 32'h1);
        rd_lit("R11 set alias ignored", 12'h000, 32'h1);
        wr(12'h00C, 32'h1);
        rd_lit("R11 toggle alias ignored", 12'h000, 32'h1);
        wr(12'h000, 32'h1);
        rd_lit("R11 w1c", 12'h000, 0);

        // R10: flag without request enable
        wr(12'h098, 32'h1);
        wr(12'h014, 32'h1);
        idle(10);
        rd_model("R10 flag no irq", 12'h000);
        wr(12'h018, 32'h1);
        wr(12'h008, 32'hF);
        rd_lit("R11 clear alias", 12'h000, 0);

        // R9: one-shot on channel 3
        wr(12'h094, 32'hE00);
        wr(12'h0D0, 32'h5);
        wr(12'h014, 32'h8);
        idle(15);
        rd_model("R9 ctrl", 12'h010);
        rd_lit("R9 cnt3 zero", 12'h060, 0);
        rd_lit("R9 flag3", 12'h000, 32'h8);

        // R9: halt without zero on channel 2
        wr(12'h014, 32'h40);
        idle(2);
        wr(12'h018, 32'h40);
        wr(12'h028, 32'h100);
        wr(12'h094, 32'h100);
        wr(12'h0C0, 32'h6);
        wr(12'h014, 32'h4);
        idle(15);
        rd_lit("R9 cnt2 held", 12'h050, 32'h6);
        rd_model("R9 ctrl2 dropped", 12'h010);

        // R12: non-timer source freezes channel 1
        wr(12'h184, 32'h4);
        wr(12'h014, 32'h2);
        rd(12'h040, a0);
        idle(5);
        rd(12'h040, a1);
        check("R12 frozen", a1, a0);
        rd_model("R12 cnt1", 12'h040);
        wr(12'h018, 32'h2);

        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule